// File: doc/BRIEF.md
# Button Press Event Decoder

This block turns six already-debounced button levels into player commands. One button is the power key and the other five serve volume down, volume up, previous track, next track and a feature key. The levels are looked at only on a slow scan tick (about 16 per second). Each press is measured in scan ticks and classed as short or long. A short press and a long press on the same key issue different commands. The volume keys and the seek keys keep stepping while they are held long. The short action of the previous key depends on a status flag that says whether the current track has played for at least five seconds.

Every command leaves the block as a one-cycle strobe. The block also holds two small pieces of state that the feature key changes: a spatial-processing mode (off, minimal, normal, extreme, counted 0 to 3) and a random-play flag. When several keys are down together, only the lowest-numbered key in the press is acted on, and nothing new starts until every key has been released. Key numbering on `keyLevel` is: bit 0 power, bit 1 volume down, bit 2 volume up, bit 3 previous, bit 4 next, bit 5 feature. A bit set to 1 means the key is pressed.

Top module: `keyCmdDecoder`

## Requirements
- R1: While reset is asserted and just after it, every command strobe is low, `spatialMode` is 0 (off) and `randomOn` is 0.
- R2: `keyLevel` and `playedFiveSec` are sampled only in cycles where `scanTick` is high. Key activity with `scanTick` low creates no strobe and does not start a press.
- R3: A press starts on the first tick with any key down, and the lowest-numbered key then down is locked. The other keys are ignored until a tick finds all keys released. A press ends when the locked key is released, even if other keys are still down.
- R4: A press lasts N ticks, where N is the number of ticks on which the locked key was seen down. N below LONG_TICKS (default 16) is short, and its command comes on the release tick. N of LONG_TICKS or more is long, and its release tick issues nothing.
- R5: A short power press strobes `pauseToggle`. On the tick where the power press reaches OFF_TICKS (default 32) ticks, `powerOffReq` strobes once.
- R6: A short volume press gives one `volDown`/`volUp` step. During a long press the key steps once on every tick from tick LONG_TICKS onward while it is held.
- R7: A short previous press strobes `restartTrack` if `playedFiveSec` is high on the release tick, and `prevTrack` if it is low. During a long press it strobes `rewindStep` on every held tick from tick LONG_TICKS onward.
- R8: A short next press strobes `nextTrack`. During a long press it strobes `fastFwdStep` on every held tick from tick LONG_TICKS onward.
- R9: A short feature press strobes `modeAdvance` and steps `spatialMode` 0→1→2→3→0. The mode changes on no other event.
- R10: On the tick where a feature press reaches LONG_TICKS ticks, `randomToggle` strobes once and `randomOn` inverts. When this turns random play on, `nextTrack` strobes in the same cycle.
- R11: Each strobe is high for exactly one cycle, the cycle right after the clock edge that sampled `scanTick` high.
- R12: At most one strobe is high in any cycle. The only exception is `nextTrack` together with `randomToggle` when random play is being enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| scanTick | input | 1 | One-cycle scan enable, about 16 Hz |
| keyLevel | input | 6 | Debounced key levels, 1 = pressed |
| playedFiveSec | input | 1 | Current track has played at least 5 s |
| pauseToggle | output | 1 | Pause/play toggle strobe |
| volDown | output | 1 | Volume down step strobe |
| volUp | output | 1 | Volume up step strobe |
| prevTrack | output | 1 | Previous track strobe |
| restartTrack | output | 1 | Restart current track strobe |
| nextTrack | output | 1 | Next track strobe |
| rewindStep | output | 1 | Rewind step strobe |
| fastFwdStep | output | 1 | Fast-forward step strobe |
| modeAdvance | output | 1 | Spatial mode advanced strobe |
| randomToggle | output | 1 | Random play toggled strobe |
| powerOffReq | output | 1 | Power-off request strobe |
| spatialMode | output | MODE_W (2) | Spatial mode, 0 off … 3 extreme |
| randomOn | output | 1 | Random play active |

## Verification
Each result is due one cycle after the clock edge that sampled `scanTick` high: the strobes, the new `spatialMode` and the new `randomOn` all appear together in that cycle, and every strobe is low again one cycle later. The bench drives each tick for exactly one cycle from the falling edge. It reads all outputs at the next falling edge, halfway through the cycle in which they are due. It compares them with a tick-by-tick model of the press rules, then checks one falling edge later that no strobe is left. Between ticks it also holds keys with `scanTick` low, to show that no command appears and no press is started.

// File: rtl/keyCmdPkg.sv
package keyCmdPkg;
  localparam int KEY_COUNT = 6;

  typedef enum logic [2:0] {
    KEY_POWER = 3'd0,
    KEY_VOLDN = 3'd1,
    KEY_VOLUP = 3'd2,
    KEY_PREV  = 3'd3,
    KEY_NEXT  = 3'd4,
    KEY_FEAT  = 3'd5
  } keyIdT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HELD = 2'd1,
    ST_WAIT = 2'd2
  } scanStateT;

  // command strobes from control to datapath
  typedef struct packed {
    logic pause;
    logic volDn;
    logic volUp;
    logic prev;
    logic restart;
    logic next;
    logic rewind;
    logic ffwd;
    logic mode;
    logic random;
    logic off;
  } cmdStrobeT;
endpackage

// File: rtl/keyScanCtrl.sv
module keyScanCtrl
  import keyCmdPkg::*;
#(
  parameter int LONG_TICKS = 16,
  parameter int OFF_TICKS  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scanTick,
  input  logic [KEY_COUNT-1:0] keyLevel,
  input  logic                 playedFiveSec,
  output cmdStrobeT            cmd
);
  localparam int CNT_W = $clog2(OFF_TICKS + 1);
  localparam logic [CNT_W-1:0] LONG_C = CNT_W'(LONG_TICKS);
  localparam logic [CNT_W-1:0] OFF_C  = CNT_W'(OFF_TICKS);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  scanStateT        state, stateNxt;
  keyIdT            lockKey, lockNxt, lowKey;
  logic [CNT_W-1:0] holdCnt, cntNxt, cntInc;
  logic             anyKey, lockedDown, longNow;

  assign anyKey = |keyLevel;

  // lowest-numbered key that is down
  always_comb begin
    lowKey = KEY_POWER;
    for (int i = KEY_COUNT - 1; i >= 0; i--) begin
      if (keyLevel[i]) lowKey = keyIdT'(i);
    end
  end

  assign lockedDown = keyLevel[lockKey];
  assign cntInc     = (holdCnt == OFF_C) ? holdCnt : holdCnt + ONE_C;
  assign longNow    = (cntInc >= LONG_C);

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    cntNxt   = holdCnt;
    lockNxt  = lockKey;
    if (scanTick) begin
      case (state)
        ST_IDLE: begin
          if (anyKey) begin
            lockNxt  = lowKey;
            cntNxt   = ONE_C;
            stateNxt = ST_HELD;
          end
        end
        ST_HELD: begin
          if (lockedDown) begin
            cntNxt = cntInc;
            case (lockKey)
              KEY_POWER: cmd.off    = (holdCnt == OFF_C - ONE_C);
              KEY_VOLDN: cmd.volDn  = longNow;
              KEY_VOLUP: cmd.volUp  = longNow;
              KEY_PREV:  cmd.rewind = longNow;
              KEY_NEXT:  cmd.ffwd   = longNow;
              KEY_FEAT:  cmd.random = (holdCnt == LONG_C - ONE_C);
              default:   cmd        = '0;
            endcase
          end else begin
            if (holdCnt < LONG_C) begin
              case (lockKey)
                KEY_POWER: cmd.pause = 1'b1;
                KEY_VOLDN: cmd.volDn = 1'b1;
                KEY_VOLUP: cmd.volUp = 1'b1;
                KEY_PREV: begin
                  cmd.restart = playedFiveSec;
                  cmd.prev    = !playedFiveSec;
                end
                KEY_NEXT:  cmd.next  = 1'b1;
                KEY_FEAT:  cmd.mode  = 1'b1;
                default:   cmd       = '0;
              endcase
            end
            stateNxt = anyKey ? ST_WAIT : ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (!anyKey) stateNxt = ST_IDLE;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lockKey <= KEY_POWER;
      holdCnt <= '0;
    end else begin
      state   <= stateNxt;
      lockKey <= lockNxt;
      holdCnt <= cntNxt;
    end
  end
endmodule

// File: rtl/keyCmdPath.sv
module keyCmdPath
  import keyCmdPkg::*;
#(
  parameter int MODE_COUNT = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cmdStrobeT                     cmd,
  output cmdStrobeT                     strobeQ,
  output logic [$clog2(MODE_COUNT)-1:0] modeQ,
  output logic                          randomQ
);
  localparam int MODE_W = $clog2(MODE_COUNT);
  localparam logic [MODE_W-1:0] MODE_LAST = MODE_W'(MODE_COUNT - 1);

  cmdStrobeT         strobeD;
  logic [MODE_W-1:0] modeD;

  always_comb begin
    strobeD      = cmd;
    strobeD.next = cmd.next | (cmd.random & !randomQ);
  end

  generate
    if (MODE_COUNT == (1 << MODE_W)) begin : g_pow2Wrap
      assign modeD = cmd.mode ? modeQ + MODE_W'(1) : modeQ;
    end else begin : g_cmpWrap
      assign modeD = !cmd.mode ? modeQ :
                     (modeQ == MODE_LAST) ? '0 : modeQ + MODE_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ <= '0;
      modeQ   <= '0;
      randomQ <= 1'b0;
    end else begin
      strobeQ <= strobeD;
      modeQ   <= modeD;
      randomQ <= randomQ ^ cmd.random;
    end
  end
endmodule

// File: rtl/keyCmdDecoder.sv
module keyCmdDecoder
  import keyCmdPkg::*;
#(
  parameter int LONG_TICKS = 16,
  parameter int OFF_TICKS  = 32,
  parameter int MODE_COUNT = 4,
  localparam int MODE_W    = $clog2(MODE_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scanTick,
  input  logic [KEY_COUNT-1:0] keyLevel,
  input  logic                 playedFiveSec,
  output logic                 pauseToggle,
  output logic                 volDown,
  output logic                 volUp,
  output logic                 prevTrack,
  output logic                 restartTrack,
  output logic                 nextTrack,
  output logic                 rewindStep,
  output logic                 fastFwdStep,
  output logic                 modeAdvance,
  output logic                 randomToggle,
  output logic                 powerOffReq,
  output logic [MODE_W-1:0]    spatialMode,
  output logic                 randomOn
);
  cmdStrobeT cmd, strobeQ;

  keyScanCtrl #(
    .LONG_TICKS(LONG_TICKS),
    .OFF_TICKS (OFF_TICKS)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .scanTick     (scanTick),
    .keyLevel     (keyLevel),
    .playedFiveSec(playedFiveSec),
    .cmd          (cmd)
  );

  keyCmdPath #(
    .MODE_COUNT(MODE_COUNT)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .strobeQ(strobeQ),
    .modeQ  (spatialMode),
    .randomQ(randomOn)
  );

  assign pauseToggle  = strobeQ.pause;
  assign volDown      = strobeQ.volDn;
  assign volUp        = strobeQ.volUp;
  assign prevTrack    = strobeQ.prev;
  assign restartTrack = strobeQ.restart;
  assign nextTrack    = strobeQ.next;
  assign rewindStep   = strobeQ.rewind;
  assign fastFwdStep  = strobeQ.ffwd;
  assign modeAdvance  = strobeQ.mode;
  assign randomToggle = strobeQ.random;
  assign powerOffReq  = strobeQ.off;
endmodule

// File: rtl/keyCmdDecoderChk.sv
module keyCmdDecoderChk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              scanTick,
  input logic              pauseToggle,
  input logic              volDown,
  input logic              volUp,
  input logic              prevTrack,
  input logic              restartTrack,
  input logic              nextTrack,
  input logic              rewindStep,
  input logic              fastFwdStep,
  input logic              modeAdvance,
  input logic              randomToggle,
  input logic              powerOffReq,
  input logic [MODE_W-1:0] spatialMode,
  input logic              randomOn
);
  logic [9:0] notNext;
  logic       anyStrobe;

  assign notNext = {pauseToggle, volDown, volUp, prevTrack, restartTrack,
                    rewindStep, fastFwdStep, modeAdvance, randomToggle, powerOffReq};
  assign anyStrobe = (|notNext) | nextTrack;

  // R11
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> $past(scanTick));

  // R12
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(notNext));

  // R12
  next_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    nextTrack |-> ((notNext & ~10'b0000000010) == 10'd0));

  // R9
  mode_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeAdvance |-> (spatialMode == MODE_W'($past(spatialMode) + MODE_W'(1))));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeAdvance |-> $stable(spatialMode));

  // R10
  random_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    randomToggle |-> (randomOn != $past(randomOn)));

  // R10
  random_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !randomToggle |-> $stable(randomOn));

  // R10
  random_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (randomToggle && randomOn) |-> nextTrack);
endmodule

bind keyCmdDecoder keyCmdDecoderChk #(.MODE_W(MODE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .scanTick    (scanTick),
  .pauseToggle (pauseToggle),
  .volDown     (volDown),
  .volUp       (volUp),
  .prevTrack   (prevTrack),
  .restartTrack(restartTrack),
  .nextTrack   (nextTrack),
  .rewindStep  (rewindStep),
  .fastFwdStep (fastFwdStep),
  .modeAdvance (modeAdvance),
  .randomToggle(randomToggle),
  .powerOffReq (powerOffReq),
  .spatialMode (spatialMode),
  .randomOn    (randomOn)
);

// File: tb/keyCmdDecoder_bench.sv
module keyCmdDecoder_bench;
  localparam int LONG = 16;
  localparam int OFFT = 32;
  // expected-vector bit positions
  localparam int B_PAUSE = 10, B_VDN = 9, B_VUP = 8, B_PREV = 7, B_RST = 6;
  localparam int B_NEXT = 5, B_REW = 4, B_FF = 3, B_MODE = 2, B_RAND = 1, B_OFF = 0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scanTick = 1'b0;
  logic [5:0] keyLevel = '0;
  logic       playedFiveSec = 1'b0;
  logic       pauseToggle, volDown, volUp, prevTrack, restartTrack, nextTrack;
  logic       rewindStep, fastFwdStep, modeAdvance, randomToggle, powerOffReq;
  logic [1:0] spatialMode;
  logic       randomOn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  int       mState = 0;
  int       mKey   = 0;
  int       mCnt   = 0;
  logic [1:0] mMode = '0;
  logic     mRand  = 1'b0;

  always #2.5 clk = ~clk;

  keyCmdDecoder u_keyCmdDecoder (
    .clk(clk), .rstN(rstN), .scanTick(scanTick), .keyLevel(keyLevel),
    .playedFiveSec(playedFiveSec), .pauseToggle(pauseToggle), .volDown(volDown),
    .volUp(volUp), .prevTrack(prevTrack), .restartTrack(restartTrack),
    .nextTrack(nextTrack), .rewindStep(rewindStep), .fastFwdStep(fastFwdStep),
    .modeAdvance(modeAdvance), .randomToggle(randomToggle), .powerOffReq(powerOffReq),
    .spatialMode(spatialMode), .randomOn(randomOn)
  );

  function automatic logic [10:0] outVec();
    return {pauseToggle, volDown, volUp, prevTrack, restartTrack, nextTrack,
            rewindStep, fastFwdStep, modeAdvance, randomToggle, powerOffReq};
  endfunction

  function automatic int lowestKey(input logic [5:0] k);
    for (int i = 0; i < 6; i++) if (k[i]) return i;
    return 0;
  endfunction

  task automatic checkOut(input string tag, input logic [10:0] eVec,
                          input logic [1:0] eMode, input logic eRand);
    checks++;
    if (outVec() !== eVec || spatialMode !== eMode || randomOn !== eRand) begin
      fails++;
      $display("FAIL %s: strobes=%b mode=%0d random=%0b expected strobes=%b mode=%0d random=%0b",
               tag, outVec(), spatialMode, randomOn, eVec, eMode, eRand);
    end
  endtask

  // press rules, one scan tick
  task automatic modelStep(input logic [5:0] k, input logic played, output logic [10:0] e);
    int prevCnt;
    bit lng;
    e = '0;
    case (mState)
      0: if (k != 0) begin mKey = lowestKey(k); mCnt = 1; mState = 1; end
      1: begin
        if (k[mKey]) begin
          prevCnt = mCnt;
          if (mCnt < OFFT) mCnt++;
          lng = (mCnt >= LONG);
          case (mKey)
            0: e[B_OFF]  = (prevCnt == OFFT - 1);
            1: e[B_VDN]  = lng;
            2: e[B_VUP]  = lng;
            3: e[B_REW]  = lng;
            4: e[B_FF]   = lng;
            default: e[B_RAND] = (prevCnt == LONG - 1);
          endcase
        end else begin
          if (mCnt < LONG) begin
            case (mKey)
              0: e[B_PAUSE] = 1'b1;
              1: e[B_VDN]   = 1'b1;
              2: e[B_VUP]   = 1'b1;
              3: if (played) e[B_RST] = 1'b1; else e[B_PREV] = 1'b1;
              4: e[B_NEXT]  = 1'b1;
              default: e[B_MODE] = 1'b1;
            endcase
          end
          mState = (k == 0) ? 0 : 2;
        end
      end
      default: if (k == 0) mState = 0;
    endcase
    if (e[B_RAND]) begin
      if (!mRand) e[B_NEXT] = 1'b1;
      mRand = !mRand;
    end
    if (e[B_MODE]) mMode = mMode + 2'd1;
  endtask

  // one scan tick: drive, check the cycle after, check strobes gone one cycle later (R11)
  task automatic doTick(input logic [5:0] k, input logic played, input string tag);
    logic [10:0] e;
    @(negedge clk);
    keyLevel = k; playedFiveSec = played; scanTick = 1'b1;
    modelStep(k, played, e);
    @(negedge clk);
    scanTick = 1'b0;
    checkOut(tag, e, mMode, mRand);
    @(negedge clk);
    checkOut({tag, " R11 strobe cleared"}, '0, mMode, mRand);
  endtask

  task automatic press(input int key, input int n, input logic played,
                       input logic [5:0] extra, input string tag);
    for (int t = 0; t < n; t++) doTick(6'(1 << key) | extra, played, tag);
    doTick(6'd0, played, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    checkOut("R1 in reset", '0, 2'd0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", '0, 2'd0, 1'b0);

    // R2: keys held without ticks do nothing
    keyLevel = 6'b000001;
    repeat (10) begin
      @(negedge clk);
      checkOut("R2 no tick", '0, 2'd0, 1'b0);
    end
    keyLevel = '0;
    doTick(6'd0, 1'b0, "R2 idle tick");

    press(0, 3, 1'b0, '0, "R5 short power");
    press(0, OFFT + 3, 1'b0, '0, "R5 long power");
    press(1, LONG - 1, 1'b0, '0, "R4 short edge");
    press(1, LONG, 1'b0, '0, "R4 long edge");
    press(2, LONG + 5, 1'b0, '0, "R6 volume repeat");
    press(2, 1, 1'b0, '0, "R6 volume single");
    press(3, 4, 1'b1, '0, "R7 restart");
    press(3, 4, 1'b0, '0, "R7 previous");
    press(3, LONG + 3, 1'b0, '0, "R7 rewind");
    press(4, 2, 1'b0, '0, "R8 next");
    press(4, LONG + 4, 1'b0, '0, "R8 fast forward");
    for (int i = 0; i < 5; i++) press(5, 2, 1'b0, '0, "R9 mode wrap");
    press(5, LONG + 2, 1'b0, '0, "R10 random on");
    press(5, LONG, 1'b0, '0, "R10 random off");

    // R3: two keys together, lowest wins; others ignored until all released
    doTick(6'b011000, 1'b0, "R3 lock");
    doTick(6'b011000, 1'b0, "R3 lock");
    doTick(6'b010000, 1'b1, "R3 release locked");
    doTick(6'b010010, 1'b0, "R3 wait");
    doTick(6'b000010, 1'b0, "R3 wait");
    doTick(6'b000000, 1'b0, "R3 all up");
    doTick(6'b010000, 1'b0, "R3 fresh");
    doTick(6'b010010, 1'b0, "R3 ignore other");
    doTick(6'b000010, 1'b0, "R3 release");
    doTick(6'b000000, 1'b0, "R3 all up");

    // constrained random presses
    for (int s = 0; s < 250; s++) begin
      int   k, n;
      logic pl;
      logic [5:0] extra;
      k  = $urandom % 6;
      n  = 1 + ($urandom % 40);
      pl = 1'($urandom % 2);
      extra = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
      for (int t = 0; t < n; t++) begin
        doTick(6'(1 << k) | ((t > 0) ? extra : 6'd0), pl, "random press");
        if ($urandom % 8 == 0) repeat (2) @(negedge clk);
      end
      doTick(extra & 6'($urandom), pl, "random release");
      doTick(6'd0, pl, "random idle");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule